// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block controls one 32-pin parallel I/O port from a simple word-addressed register bus. Every configuration attribute of a pin is kept in an internal state word. Software never writes that word directly. It changes bits only through a pair of addresses: one sets the bits written as 1, and the other clears them. It reads the current value back from a third address. There are eight attributes. They decide whether GPIO or a peripheral owns the pin, which of two peripherals is selected, the output enable, the output data, the pull-up, the input glitch filter, the open-drain drive and the interrupt mask.

On the input side, each pad passes through a two-flop synchroniser and, if its filter is enabled, through a per-pin glitch filter. It then feeds a both-edge change detector. Detected changes collect in a pending status word. Reading that word returns it and clears it in the same access. A single interrupt line is raised while any pending bit is also unmasked. The synchronised pad level can always be read, whoever owns the pin.

Top module: `gpsc_port`

## Requirements
- R1: After reset the status reads give: ownership all ones (GPIO), peripheral select 0, output enable 0, output data 0, pull-up all ones, filter 0, open-drain 0, interrupt mask 0 and pending status 0. The interrupt line is low.
- R2: Attribute k has its set address at word 3k, its clear address at 3k+1 and its status address at 3k+2. The attributes are numbered ownership 0, peripheral select 1, output enable 2, output data 3, pull-up 4, filter 5, open-drain 6, interrupt mask 7. A 1 in a written bit sets or clears that bit from the next cycle on, and a 0 leaves it unchanged. Unmapped addresses read 0.
- R3: A peripheral-select bit of 1 selects peripheral B for that pin, and 0 selects peripheral A. The status word reads 1 where B is selected.
- R4: For a pin owned by GPIO (ownership bit 1), the pad output enable follows the output-enable bit and the pad value follows the output-data bit. For a pin not owned by GPIO, both follow the selected peripheral's output and enable.
- R5: The pad pull-up output equals the pull-up attribute word.
- R6: For a pin with open-drain set, a driven value of 1 turns the pad output enable off, and a driven value of 0 enables the pad with value 0.
- R7: The pin-level address (word 0x18) returns the pad levels through the two-flop synchroniser, whether or not GPIO owns the pins.
- R8: A rising or falling change on any pin sets that pin's bit in the pending status (word 0x19).
- R9: A read of word 0x19 returns the pending bits and clears them at the end of that cycle. A change detected in the same cycle stays pending.
- R10: The interrupt line is high exactly when the pending status ANDed with the interrupt mask is non-zero.
- R11: With the filter enabled for a pin, an input level reaches change detection only after it has been stable for FILT_LEN (default 2) clock cycles, so a one-cycle pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Word address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rd | input | 1 | Read strobe (a read of 0x19 clears pending status) |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pullup | output | 32 | Pad pull-up enables |
| per_a_out | input | 32 | Peripheral A output values |
| per_a_oe | input | 32 | Peripheral A output enables |
| per_b_out | input | 32 | Peripheral B output values |
| per_b_oe | input | 32 | Peripheral B output enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume at most one bus access per cycle, so that a set write and a clear write of the same word never meet. They also assume the filter length is at least two. Pad inputs may change at any time, because the synchroniser sits in front of everything that the assertions watch. The stimulus drives every input on the falling clock edge and issues one access at a time. It keeps a pin's level settled before turning that pin's filter on, so enabling the filter does not itself look like a change.

// File: rtl/gpsc_pkg.sv
// Shared constants for the set/clear GPIO port.
// Assumes word addressing; attribute k uses words 3k, 3k+1, 3k+2.
package gpsc_pkg;
    localparam int NUM_ATTR  = 8;
    localparam int ATTR_OWN  = 0;
    localparam int ATTR_BSEL = 1;
    localparam int ATTR_OE   = 2;
    localparam int ATTR_DOUT = 3;
    localparam int ATTR_PU   = 4;
    localparam int ATTR_FILT = 5;
    localparam int ATTR_OD   = 6;
    localparam int ATTR_IM   = 7;
    localparam int WORD_PIN  = 8'h18;
    localparam int WORD_ISR  = 8'h19;
endpackage

// File: rtl/gpsc_attr_bank.sv
// One attribute word changed only through set and clear strobes.
// Assumes set_we and clr_we are never high together (one access per cycle).
module gpsc_attr_bank #(
    parameter int W        = 32,
    parameter bit RST_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Hold the attribute; set or clear only the bits written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RST_ONES ? '1 : '0;
        else if (set_we) q <= q | wdata;
        else if (clr_we) q <= q & ~wdata;
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((q & $past(wdata)) == $past(wdata)));
    // R2
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((q & $past(wdata)) == '0));
    // R2
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we || clr_we) |=> (((q ^ $past(q)) & ~$past(wdata)) == '0));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> (q == $past(q)));
endmodule

// File: rtl/gpsc_input_path.sv
// Pad input path: two-flop synchroniser, optional per-pin glitch filter,
// and a both-edge change detector.
// Assumes pads are asynchronous; FILT_LEN >= 1 (assertion needs >= 2).
module gpsc_input_path #(
    parameter int W        = 32,
    parameter int FILT_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] filt_en,
    output logic [W-1:0] level,
    output logic [W-1:0] change
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [W-1:0] sync1, sync2, filt, sel, prev;

    // Bring the asynchronous pad levels into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= pad_in;
            sync2 <= sync1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_filt
        logic [CW-1:0] cnt;
        logic          fbit;
        // Accept a new level only after FILT_LEN cycles of disagreement.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt  <= '0;
                fbit <= 1'b0;
            end else if (sync2[i] == fbit) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                fbit <= sync2[i];
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
        assign filt[i] = fbit;
    end

    assign sel    = (filt_en & filt) | (~filt_en & sync2);
    assign level  = sync2;
    assign change = sel ^ prev;

    // Remember the last detector input to find both edges.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= sel;
    end

    if (FILT_LEN >= 2) begin : g_fchk
        // R11
        filt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((filt ^ $past(filt)) &
             ((filt ^ $past(sync2)) | ($past(sync2) ^ $past(sync2, 2)))) == '0);
    end
endmodule

// File: rtl/gpsc_pad_mux.sv
// Chooses the pad drive from GPIO or the selected peripheral, then applies
// open-drain. Purely combinational; assumes all inputs are registered upstream.
module gpsc_pad_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] bsel,
    input  logic [W-1:0] oe,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] od,
    input  logic [W-1:0] pa_out,
    input  logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_out,
    input  logic [W-1:0] pb_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    logic [W-1:0] per_val, per_oe, drv_val, drv_oe;

    // Select the source, then turn driven ones into release under open-drain.
    always_comb begin
        per_val = (bsel & pb_out) | (~bsel & pa_out);
        per_oe  = (bsel & pb_oe)  | (~bsel & pa_oe);
        drv_val = (own & dout) | (~own & per_val);
        drv_oe  = (own & oe)   | (~own & per_oe);
        pad_oe  = drv_oe & ~(od & drv_val);
        pad_out = drv_val & ~od;
    end
endmodule

// File: rtl/gpsc_port.sv
// 32-pin port controller top: address decode, eight set/clear attribute
// words, read mux, clear-on-read pending status and interrupt line.
// Assumes one bus access per cycle; read data valid in the strobe cycle.
module gpsc_port
    import gpsc_pkg::*;
#(
    parameter int W        = 32,
    parameter int AW       = 6,
    parameter int FILT_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    input  logic          bus_rd,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_pullup,
    input  logic [W-1:0]  per_a_out,
    input  logic [W-1:0]  per_a_oe,
    input  logic [W-1:0]  per_b_out,
    input  logic [W-1:0]  per_b_oe,
    output logic          irq
);
    logic [W-1:0] attr_q [NUM_ATTR];
    logic [W-1:0] level, change, isr;
    logic         ack;

    for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
        localparam bit ONES = (k == ATTR_OWN) || (k == ATTR_PU);
        logic [W-1:0] q;
        gpsc_attr_bank #(.W(W), .RST_ONES(ONES)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (bus_wr && (bus_addr == AW'(3 * k))),
            .clr_we (bus_wr && (bus_addr == AW'(3 * k + 1))),
            .wdata  (bus_wdata),
            .q      (q)
        );
        assign attr_q[k] = q;
    end

    gpsc_input_path #(.W(W), .FILT_LEN(FILT_LEN)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .filt_en (attr_q[ATTR_FILT]),
        .level   (level),
        .change  (change)
    );

    gpsc_pad_mux #(.W(W)) u_mux (
        .own     (attr_q[ATTR_OWN]),
        .bsel    (attr_q[ATTR_BSEL]),
        .oe      (attr_q[ATTR_OE]),
        .dout    (attr_q[ATTR_DOUT]),
        .od      (attr_q[ATTR_OD]),
        .pa_out  (per_a_out),
        .pa_oe   (per_a_oe),
        .pb_out  (per_b_out),
        .pb_oe   (per_b_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign pad_pullup = attr_q[ATTR_PU];
    assign ack        = bus_rd && (bus_addr == AW'(WORD_ISR));

    // Collect changes; a status read clears only what was pending before.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (ack ? '0 : isr) | change;
    end

    // Return the word at bus_addr: attribute status, pin level or pending.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_ATTR; k++)
            if (bus_addr == AW'(3 * k + 2)) bus_rdata = attr_q[k];
        if (bus_addr == AW'(WORD_PIN)) bus_rdata = level;
        if (bus_addr == AW'(WORD_ISR)) bus_rdata = isr;
    end

    assign irq = |(isr & attr_q[ATTR_IM]);

    // R9
    isr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ((isr & ~$past(change)) == '0));
    // R8
    isr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|change) |=> (($past(change) & ~isr) == '0));
endmodule

// File: tb/test_gpsc_port.sv
`timescale 1ns/1ps
module test_gpsc_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pullup;
    logic [31:0] per_a_out = 32'hAAAA_AAAA, per_a_oe = '1;
    logic [31:0] per_b_out = 32'h5555_5555, per_b_oe = '1;
    logic        irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpsc_port i_gpsc_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pullup(pad_pullup), .per_a_out(per_a_out), .per_a_oe(per_a_oe),
        .per_b_out(per_b_out), .per_b_oe(per_b_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int k = 0; k < 8; k++) begin
            rd(6'(3 * k + 2), d);
            chk($sformatf("R1 status attr %0d", k), d,
                (k == 0 || k == 4) ? 32'hFFFF_FFFF : 32'h0);
        end
        rd(6'h19, d);
        chk("R1 pending", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        wr(6'h06, 32'h0000_00F0); rd(6'h08, d); chk("R2 set oe", d, 32'h0000_00F0);
        wr(6'h06, 32'h0000_0F00); rd(6'h08, d); chk("R2 set keeps zeros", d, 32'h0000_0FF0);
        wr(6'h07, 32'h0000_0030); rd(6'h08, d); chk("R2 clear oe", d, 32'h0000_0FC0);
        wr(6'h07, 32'hFFFF_FFFF); rd(6'h08, d); chk("R2 clear all", d, 32'h0);
        rd(6'h3F, d); chk("R2 unmapped", d, 32'h0);
        wr(6'h0D, 32'hFFFF_0000);
        chk("R5 pullup out", pad_pullup, 32'h0000_FFFF);
        wr(6'h0C, 32'hFFFF_FFFF);
        chk("R5 pullup restored", pad_pullup, 32'hFFFF_FFFF);
    endtask

    task automatic t_mux();
        logic [31:0] d;
        wr(6'h06, 32'h1); wr(6'h09, 32'h1);
        chk("R4 gpio oe", pad_oe, 32'h1);
        chk("R4 gpio out", pad_out, 32'h1);
        wr(6'h01, 32'hFFFF_FFFF);
        chk("R4 periph A out", pad_out, 32'hAAAA_AAAA);
        chk("R4 periph oe", pad_oe, 32'hFFFF_FFFF);
        wr(6'h03, 32'h0000_FFFF);
        chk("R3 periph B low half", pad_out, 32'hAAAA_5555);
        rd(6'h05, d); chk("R3 select status", d, 32'h0000_FFFF);
        wr(6'h04, 32'hFFFF_FFFF); wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h07, 32'h1); wr(6'h0A, 32'h1);
        chk("R4 back to gpio input", pad_oe, 32'h0);
    endtask

    task automatic t_od();
        wr(6'h12, 32'h4); wr(6'h06, 32'h4); wr(6'h09, 32'h4);
        chk("R6 one releases", pad_oe, 32'h0);
        wr(6'h0A, 32'h4);
        chk("R6 zero drives oe", pad_oe, 32'h4);
        chk("R6 zero drives low", pad_out, 32'h0);
        wr(6'h07, 32'h4); wr(6'h13, 32'h4);
    endtask

    task automatic t_level_edges();
        logic [31:0] d;
        wr(6'h01, 32'hFFFF_FFFF);
        @(negedge clk); pad_in = 32'h1234_5678;
        idle(3);
        rd(6'h18, d); chk("R7 level while peripheral owned", d, 32'h1234_5678);
        rd(6'h19, d); chk("R8 rising edges", d, 32'h1234_5678);
        @(negedge clk); pad_in = 32'h0;
        idle(4);
        rd(6'h19, d); chk("R8 falling edges", d, 32'h1234_5678);
        rd(6'h19, d); chk("R9 cleared by read", d, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(6'h15, 32'h8);
        @(negedge clk); pad_in = 32'h20;
        idle(4);
        chk("R10 masked pin no irq", {31'b0, irq}, 32'h0);
        @(negedge clk); pad_in = 32'h28;
        idle(4);
        chk("R10 unmasked pin irq", {31'b0, irq}, 32'h1);
        rd(6'h17, d); chk("R10 mask status", d, 32'h8);
        rd(6'h19, d); chk("R9 pending read", d, 32'h28);
        chk("R10 irq after read", {31'b0, irq}, 32'h0);
        @(negedge clk); pad_in = 32'h0;
        idle(4);
        chk("R10 falling irq", {31'b0, irq}, 32'h1);
        rd(6'h19, d); chk("R8 falling pending", d, 32'h28);
        wr(6'h16, 32'h8);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        @(negedge clk); pad_in = 32'h80;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 6'h19; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
        chk("R9 read before edge", d, 32'h0);
        rd(6'h19, d); chk("R9 edge kept during read", d, 32'h80);
        @(negedge clk); pad_in = 32'h0;
        idle(4);
        rd(6'h19, d);
    endtask

    task automatic t_filter();
        logic [31:0] d;
        wr(6'h0F, 32'h1);
        idle(3);
        @(negedge clk); pad_in = 32'h3;
        @(negedge clk); pad_in = 32'h0;
        idle(6);
        rd(6'h19, d); chk("R11 one-cycle pulse dropped on filtered pin", d, 32'h2);
        @(negedge clk); pad_in = 32'h1;
        idle(2);
        pad_in = 32'h0;
        idle(8);
        rd(6'h19, d); chk("R11 two-cycle pulse passes filter", d, 32'h1);
        wr(6'h10, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_setclr();
        t_mux();
        t_od();
        t_level_edges();
        t_irq();
        t_same_cycle();
        t_filter();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule